// File: doc/BRIEF.md
# Read Output Stage with Flow-Through / Pipelined Select

This block sits between the read port of a synchronous memory array and a tri-stated data bus. Each cycle the controller reports what kind of access is under way: a read, a write or a deselect. The array presents the word it read in that same cycle. A mode input, which can change at run time, chooses the output path. In one setting the array word goes straight to the bus in the same cycle. In the other it is first caught in a rising-edge output register, which adds one cycle of latency.

The stage decides when the bus is driven. Writes never drive the bus. A deselect releases the bus after a single cycle. An asynchronous active-low output enable can switch the drivers off at any moment. It can never switch them on by itself: it only permits driving in cycles that carry read data. A read issued with the enable held off is a dummy read. It keeps the bus quiet so that a write can follow a read without a deselect cycle in between. In pipelined mode the drive permission passes through the same register as the data, so data and drive always refer to the same read.

Top module: `rd_out_stage`

## Requirements
- R1: With `pipe_sel` low (flow-through), a read reported on `cyc_kind` puts `arr_rdata` on `bus_q` and drives every lane in that same cycle.
- R2: With `pipe_sel` high (pipelined), `bus_q` and `bus_drive` show the read that was reported in the previous cycle. The data is captured at the rising clock edge, and back-to-back reads stream one word per cycle.
- R3: In any cycle where `cyc_kind` is 2'b10 (write), `bus_drive` is all zeros in both modes. This holds even when the previous cycle was a read in pipelined mode.
- R4: `bus_drive` is either all zeros or all ones. Every lane is driven together during a read.
- R5: While `oe_n` is high, `bus_drive` is all zeros. The effect is immediate and needs no clock edge.
- R6: `oe_n` low never causes driving on its own. With no read data to present, the bus stays released.
- R7: A dummy read is a read with `oe_n` high. It drives nothing, and a write in the next cycle also leaves the bus undriven, so no deselect is needed to turn the bus around.
- R8: A deselect (`cyc_kind` 2'b00, or the unused code 2'b11) releases the bus in the next cycle in pipelined mode and in the same cycle in flow-through mode.
- R9: While reset is asserted, and right after it is released, the output register holds no read. Pipelined mode drives nothing until a read has been registered.
- R10: `pipe_sel` is used every cycle. Changing it switches the data and drive source in that same cycle, and the output register keeps capturing in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_sel | input | 1 | 1 = pipelined output, 0 = flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cyc_kind | input | 2 | Access type this cycle: 00 deselect, 01 read, 10 write, 11 deselect |
| arr_rdata | input | DATA_W | Word read from the array in this cycle |
| bus_q | output | DATA_W | Data presented to the bus drivers |
| bus_drive | output | LANES | Per-lane driver enable, 1 = drive |

## Verification
Suppose the registered read flag is wrong. In pipelined mode the bus is then driven, or left released, one cycle after the offending access, and the data shows up one cycle early or late. A faulty gate shows up in the same cycle: a lane driven during a write, a lane driven while the output enable is high, or lanes that do not match each other. Every error in this block reaches `bus_drive` or `bus_q` within one cycle. Each step is compared against a model that tracks the previous cycle's read and its data.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'b00,
        CYC_READ  = 2'b01,
        CYC_WRITE = 2'b10,
        CYC_SPARE = 2'b11
    } cyc_kind_t;

    function automatic logic is_read(input logic [1:0] k);
        return k == CYC_READ;
    endfunction

    function automatic logic is_write(input logic [1:0] k);
        return k == CYC_WRITE;
    endfunction

endpackage

// File: rtl/rdo_out_reg.sv
module rdo_out_reg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_now,
    input  logic [DATA_W-1:0] data_in,
    output logic              rd_q,
    output logic [DATA_W-1:0] data_q
);

    typedef struct packed {
        logic              rd;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rd   = rd_now;
        st_d.data = data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_q   = st_q.rd;
    assign data_q = st_q.data;

    AST_REG_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |=> rd_q); // R2

    AST_REG_TRACKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |=> !rd_q); // R8

endmodule

// File: rtl/rdo_drive_gate.sv
module rdo_drive_gate #(
    parameter int LANES = 4
) (
    input  logic             src_rd,
    input  logic             oe_n,
    input  logic             wr_now,
    output logic [LANES-1:0] drive
);

    logic permit;

    always_comb begin
        permit = src_rd && !oe_n && !wr_now;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign drive[g] = permit;
    end

endmodule

// File: rtl/rd_out_stage.sv
module rd_out_stage #(
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_sel,
    input  logic              oe_n,
    input  logic [1:0]        cyc_kind,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] bus_q,
    output logic [LANES-1:0]  bus_drive
);
    import rdo_pkg::*;

    localparam logic [LANES-1:0] ALL_ON = {LANES{1'b1}};

    logic              rd_now;
    logic              wr_now;
    logic              reg_rd;
    logic [DATA_W-1:0] reg_data;
    logic              src_rd;

    always_comb begin
        rd_now = is_read(cyc_kind);
        wr_now = is_write(cyc_kind);
    end

    rdo_out_reg #(.DATA_W(DATA_W)) i_out_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_now  (rd_now),
        .data_in (arr_rdata),
        .rd_q    (reg_rd),
        .data_q  (reg_data)
    );

    always_comb begin
        if (pipe_sel) begin
            src_rd = reg_rd;
            bus_q  = reg_data;
        end else begin
            src_rd = rd_now;
            bus_q  = arr_rdata;
        end
    end

    rdo_drive_gate #(.LANES(LANES)) i_gate (
        .src_rd (src_rd),
        .oe_n   (oe_n),
        .wr_now (wr_now),
        .drive  (bus_drive)
    );

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CYC_WRITE) |-> (bus_drive == '0)); // R3

    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive == '0) || (bus_drive == ALL_ON)); // R4

    AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (bus_drive == '0)); // R5

    AST_FLOW_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_sel && cyc_kind != CYC_READ) |-> (bus_drive == '0)); // R6

    AST_PIPE_DATA_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && bus_drive != '0) |-> (bus_q == $past(arr_rdata))); // R2

    AST_PIPE_DESEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && $past(cyc_kind) != CYC_READ) |-> (bus_drive == '0)); // R8

endmodule

// File: tb/test_rd_out_stage.sv
module test_rd_out_stage;

    localparam int DATA_W = 36;
    localparam int LANES  = 4;
    localparam logic [1:0] K_DES = 2'b00;
    localparam logic [1:0] K_RD  = 2'b01;
    localparam logic [1:0] K_WR  = 2'b10;
    localparam logic [1:0] K_SP  = 2'b11;

    typedef struct {
        logic              drv;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pipe_sel = 1'b0;
    logic              oe_n = 1'b1;
    logic [1:0]        cyc_kind = K_DES;
    logic [DATA_W-1:0] arr_rdata = '0;
    logic [DATA_W-1:0] bus_q;
    logic [LANES-1:0]  bus_drive;

    int n_checks = 0;
    int n_fails  = 0;
    exp_t exp_q[$];
    event sample_ev;

    logic              m_rd   = 1'b0;
    logic [DATA_W-1:0] m_data = '0;

    always #2.5 clk = ~clk;

    rd_out_stage #(.DATA_W(DATA_W), .LANES(LANES)) i_rd_out_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_sel  (pipe_sel),
        .oe_n      (oe_n),
        .cyc_kind  (cyc_kind),
        .arr_rdata (arr_rdata),
        .bus_q     (bus_q),
        .bus_drive (bus_drive)
    );

    // Monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [LANES-1:0] want;
                e = exp_q.pop_front();
                want = e.drv ? {LANES{1'b1}} : '0;
                n_checks++;
                if (bus_drive !== want) begin
                    n_fails++;
                    $display("FAIL %s: bus_drive actual %b expected %b", e.tag, bus_drive, want);
                end else if (e.drv && bus_q !== e.data) begin
                    n_fails++;
                    $display("FAIL %s: bus_q actual %h expected %h", e.tag, bus_q, e.data);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, expected value from the requirements
    task automatic step(input logic p, input logic oe, input logic [1:0] k,
                        input logic [DATA_W-1:0] d, input string tag);
        exp_t e;
        logic src;
        @(negedge clk);
        pipe_sel  = p;
        oe_n      = oe;
        cyc_kind  = k;
        arr_rdata = d;
        src    = p ? m_rd : (k == K_RD);
        e.data = p ? m_data : d;
        e.drv  = src && !oe && (k != K_WR);
        e.tag  = tag;
        exp_q.push_back(e);
        #1;
        ->sample_ev;
        m_rd   = (k == K_RD);
        m_data = d;
    endtask

    // Asynchronous enable pulse within the current cycle
    task automatic oe_pulse(input string tag);
        exp_t e;
        logic keep;
        keep = oe_n;
        #0.5;
        oe_n = 1'b1;
        e.drv = 1'b0; e.data = '0; e.tag = tag;
        exp_q.push_back(e);
        #0.5;
        ->sample_ev;
        #0.5;
        oe_n = keep;
    endtask

    initial begin
        fork
            begin
                #400000;
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: run hung, actual timeout expected completion");
            end
            begin
                // R9: reset state, pipelined mode, no drive
                pipe_sel = 1'b1; oe_n = 1'b0; cyc_kind = K_RD; arr_rdata = 36'h1;
                repeat (3) @(posedge clk);
                #1;
                begin
                    exp_t e;
                    e.drv = 1'b0; e.data = '0; e.tag = "R9 in reset";
                    exp_q.push_back(e);
                    ->sample_ev;
                end
                @(negedge clk);
                cyc_kind = K_DES;
                rst_n = 1'b1;
                m_rd = 1'b0; m_data = '0;
                step(1, 0, K_DES, 36'h0, "R9 after release");

                // Flow-through
                step(0, 0, K_RD,  36'hA_1111_0001, "R1 flow read");
                step(0, 0, K_RD,  36'hA_1111_0002, "R1 flow burst beat");
                step(0, 0, K_DES, 36'hA_1111_0003, "R8 flow deselect same cycle");
                step(0, 1, K_RD,  36'hA_1111_0004, "R7 flow dummy read");
                step(0, 0, K_WR,  36'hA_1111_0005, "R3 flow write");
                step(0, 0, K_RD,  36'hA_1111_0006, "R4 flow all lanes");
                step(0, 0, K_SP,  36'hA_1111_0007, "R6 spare code quiet");

                // Pipelined
                step(1, 0, K_RD,  36'hB_2222_0001, "R2 pipe first read hidden");
                step(1, 0, K_RD,  36'hB_2222_0002, "R2 pipe beat1");
                step(1, 0, K_RD,  36'hB_2222_0003, "R2 pipe beat2");
                step(1, 0, K_DES, 36'hB_2222_0004, "R2 pipe beat3 during deselect");
                step(1, 0, K_DES, 36'hB_2222_0005, "R8 pipe released next cycle");
                step(1, 0, K_RD,  36'hB_2222_0006, "R6 pipe read launch quiet");
                step(1, 0, K_WR,  36'hB_2222_0007, "R3 pipe write after read");
                step(1, 0, K_RD,  36'hB_2222_0008, "R6 pipe after write quiet");
                step(1, 1, K_RD,  36'hB_2222_0009, "R7 pipe dummy read");
                step(1, 0, K_WR,  36'hB_2222_000A, "R7 write after dummy");
                step(1, 0, K_RD,  36'hB_2222_000B, "R2 pipe read again");
                step(1, 0, K_DES, 36'hB_2222_000C, "R5 pipe output before pulse");
                oe_pulse("R5 async enable off");
                step(1, 1, K_DES, 36'hB_2222_000D, "R5 oe high no drive");

                // Mode switching
                step(1, 0, K_RD,  36'hC_3333_0001, "R10 pipe read");
                step(0, 0, K_DES, 36'hC_3333_0002, "R10 switch to flow quiet");
                step(0, 0, K_RD,  36'hC_3333_0003, "R10 flow read");
                step(1, 0, K_DES, 36'hC_3333_0004, "R10 switch to pipe shows captured");
                step(1, 0, K_DES, 36'hC_3333_0005, "R8 pipe idle");

                repeat (2) @(negedge clk);
                #1;
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule